// File: doc/BRIEF.md
# Paired PWM Start Coordinator

This block decides when each of two PWM channel counters may run. Every channel has a run-enable bit and a sync-enable bit, both taken from that channel's own control register. A channel whose sync-enable bit is clear starts on its own. A channel whose sync-enable bit is set and whose run-enable bit is set parks in a standby state. It leaves standby only when its partner channel's run-enable bit goes high, and at that point both channels are released on the same clock edge. The controller never copies settings from one channel to the other. It only gates the counters.

Outputs for each channel are a run level, a standby status, and single-cycle start and stop pulses. The counter logic uses the run level as its count enable and the stop pulse as its clear. Channels are grouped in pairs (0,1), (2,3) and so on. Each pair is independent of every other pair.

Top module: `dual_sync_start`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `run_o`, `standby_o`, `start_o` and `stop_o` are all 0.
- R2: When a channel with its sync bit (`sync_en[i]`) at 0 has `run_en[i]` sampled high at a clock edge, that channel's `run_o[i]` is 1 in the cycle after that edge, whatever its partner is doing.
- R3: When a channel with `sync_en[i]`=1 is enabled while its partner's `run_en` is 0, the channel goes to standby instead of running: `standby_o[i]`=1 and `run_o[i]`=0 from the next cycle on. If the partner's `run_en` is already 1, the channel runs at once.
- R4: A channel in standby leaves standby and runs in the cycle after the edge at which its partner's `run_en` is sampled high. The partner starts on that same edge, so both `run_o` bits rise together.
- R5: Setting `sync_en` and `run_en` of both channels in the same cycle starts both channels together on the next edge.
- R6: Sampling `run_en[i]`=0 at an edge stops the channel: `run_o[i]`=0 and `standby_o[i]`=0 in the next cycle.
- R7: Clearing `run_en[i]` while the channel is in standby cancels the standby, and the channel never runs.
- R8: `start_o[i]` is 1 for exactly the first cycle in which `run_o[i]` is 1. `stop_o[i]` is 1 for exactly the first cycle in which `run_o[i]` is 0 after running, and serves as the counter clear.
- R9: Clearing `sync_en[i]` while the channel waits in standby releases it: it runs from the next cycle.
- R10: A running channel keeps running when its partner's `run_en` drops or its partner stops.
- R11: `run_o[i]` and `standby_o[i]` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_en | input | NCH | Per-channel synchronized-start enable (bit i = channel i) |
| run_en | input | NCH | Per-channel run enable (bit i = channel i) |
| run_o | output | NCH | Counter count enable per channel |
| standby_o | output | NCH | Channel is waiting for its partner |
| start_o | output | NCH | One-cycle pulse when a channel starts running |
| stop_o | output | NCH | One-cycle pulse when a channel stops; clears its counter |

## Verification
The pair is driven through four kinds of input patterns. In the first, neither channel uses sync. In the second, one channel uses sync and the other does not, which shows whether the waiting channel is released by its partner's enable rather than by its own. In the third, both channels use sync and are enabled in separate cycles, and then in the same cycle, which separates first-waits-for-second behaviour from same-write starts. The fourth covers disturbances during standby and during running: dropping run-enable, clearing the sync bit, and dropping the partner. These show that standby is cancelled or released correctly and that a channel already running is never stopped by its partner.

// File: rtl/dssc_pkg.sv
package dssc_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_t;

    typedef struct packed {
        logic sync;
        logic en;
    } ch_ctl_t;

    // Next state of one channel given its own control bits and the partner's run enable.
    function automatic ch_state_t ch_next(
        input ch_state_t cur,
        input ch_ctl_t   ctl,
        input logic      peer_en
    );
        ch_state_t nxt;
        nxt = cur;
        if (!ctl.en) begin
            nxt = CH_IDLE;
        end else begin
            unique case (cur)
                CH_IDLE: nxt = (ctl.sync && !peer_en) ? CH_WAIT : CH_RUN;
                CH_WAIT: nxt = (!ctl.sync || peer_en) ? CH_RUN : CH_WAIT;
                CH_RUN:  nxt = CH_RUN;
                default: nxt = CH_IDLE;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sync_chan_fsm.sv
module sync_chan_fsm
    import dssc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_ctl_t ctl,
    input  logic    peer_en,
    output logic    run,
    output logic    standby
);

    ch_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= ch_next(state_q, ctl, peer_en);
        end
    end

    always_comb begin
        run     = (state_q == CH_RUN);
        standby = (state_q == CH_WAIT);
    end

endmodule

// File: rtl/run_edge_gen.sv
module run_edge_gen #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] run,
    output logic [NCH-1:0] start,
    output logic [NCH-1:0] stop
);

    logic [NCH-1:0] run_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_d <= '0;
        end else begin
            run_d <= run;
        end
    end

    always_comb begin
        start = run & ~run_d;
        stop  = ~run & run_d;
    end

endmodule

// File: rtl/dual_sync_start.sv
module dual_sync_start
    import dssc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] sync_en,
    input  logic [NCH-1:0] run_en,
    output logic [NCH-1:0] run_o,
    output logic [NCH-1:0] standby_o,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] stop_o
);

    localparam int NPAIR = NCH / 2;

    logic [NCH-1:0] run_w;
    logic [NCH-1:0] sb_w;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar s = 0; s < 2; s++) begin : g_side
            localparam int SELF = 2 * p + s;
            localparam int PEER = 2 * p + (1 - s);
            ch_ctl_t ctl;
            always_comb begin
                ctl.sync = sync_en[SELF];
                ctl.en   = run_en[SELF];
            end
            sync_chan_fsm u_ch (
                .clk     (clk),
                .rst     (rst),
                .ctl     (ctl),
                .peer_en (run_en[PEER]),
                .run     (run_w[SELF]),
                .standby (sb_w[SELF])
            );
        end
    end

    if (NCH > 2 * NPAIR) begin : g_odd
        assign run_w[NCH-1] = 1'b0;
        assign sb_w[NCH-1]  = 1'b0;
    end

    run_edge_gen #(.NCH(NCH)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .run   (run_w),
        .start (start_o),
        .stop  (stop_o)
    );

    assign run_o     = run_w;
    assign standby_o = sb_w;

endmodule

// File: rtl/dual_sync_start_chk.sv
module dual_sync_start_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] sync_en,
    input logic [NCH-1:0] run_en,
    input logic [NCH-1:0] run_o,
    input logic [NCH-1:0] standby_o,
    input logic [NCH-1:0] start_o,
    input logic [NCH-1:0] stop_o
);

    localparam int NPAIR = NCH / 2;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar s = 0; s < 2; s++) begin : g_side
            localparam int A = 2 * p + s;
            localparam int B = 2 * p + (1 - s);

            // R11
            excl_state_chk: assert property (@(posedge clk) disable iff (rst)
                !(run_o[A] && standby_o[A]));

            // R2
            solo_start_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(run_en[A]) && !sync_en[A]) |=> run_o[A]);

            // R3
            park_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(run_en[A]) && sync_en[A] && !run_en[B]) |=> (standby_o[A] && !run_o[A]));

            // R4
            joint_release_chk: assert property (@(posedge clk) disable iff (rst)
                (standby_o[A] && run_en[A] && run_en[B]) |=> (run_o[A] && run_o[B]));

            // R6
            halt_chk: assert property (@(posedge clk) disable iff (rst)
                !run_en[A] |=> (!run_o[A] && !standby_o[A]));

            // R7
            cancel_chk: assert property (@(posedge clk) disable iff (rst)
                (standby_o[A] && !run_en[A]) |=> !run_o[A]);

            // R8
            start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
                start_o[A] |=> !start_o[A]);

            // R10
            keep_running_chk: assert property (@(posedge clk) disable iff (rst)
                (run_o[A] && run_en[A]) |=> run_o[A]);
        end
    end

endmodule

bind dual_sync_start dual_sync_start_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_en   (sync_en),
    .run_en    (run_en),
    .run_o     (run_o),
    .standby_o (standby_o),
    .start_o   (start_o),
    .stop_o    (stop_o)
);

// File: tb/sim_dual_sync_start.sv
`timescale 1ns/1ps
module sim_dual_sync_start;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sync_en = '0;
    logic [1:0] run_en  = '0;
    logic [1:0] run_o, standby_o, start_o, stop_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dual_sync_start #(.NCH(2)) u0 (
        .clk       (clk),
        .rst       (rst),
        .sync_en   (sync_en),
        .run_en    (run_en),
        .run_o     (run_o),
        .standby_o (standby_o),
        .start_o   (start_o),
        .stop_o    (stop_o)
    );

    // {sync[1:0], en[1:0], exp_run[1:0], exp_standby[1:0]}; bit 0 = channel 0
    localparam int NV = 24;
    localparam logic [7:0] VEC [0:NV-1] = '{
        8'b00_01_01_00, // R2 ch0 alone
        8'b00_11_11_00, // R2 ch1 joins
        8'b00_00_00_00, // R6
        8'b01_01_00_01, // R3 ch0 parks
        8'b01_01_00_01, // R3 stays parked
        8'b01_11_11_00, // R4 partner release
        8'b01_10_10_00, // R6 ch0 stops, R10 ch1 keeps
        8'b11_00_00_00, // R6
        8'b11_11_11_00, // R5 same-write start
        8'b11_00_00_00, // R6
        8'b11_10_00_10, // R3 ch1 parks
        8'b11_10_00_10, // R3
        8'b11_11_11_00, // R4 both sync, second releases first
        8'b11_01_01_00, // R10 ch0 keeps
        8'b11_00_00_00, // R6
        8'b01_01_00_01, // R3
        8'b01_00_00_00, // R7 cancel
        8'b01_00_00_00, // R7 never ran
        8'b10_10_00_10, // R3 ch1 parks
        8'b00_10_10_00, // R9 sync cleared releases
        8'b00_00_00_00, // R6
        8'b10_01_01_00, // R2 ch0 solo
        8'b10_11_11_00, // R3 partner already enabled -> immediate run
        8'b00_00_00_00  // R6
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic [1:0] e);
        @(negedge clk);
        sync_en = s;
        run_en  = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", run_o, 2'b00, "run in reset");
        check("R1", standby_o, 2'b00, "standby in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", run_o | standby_o | start_o | stop_o, 2'b00, "outputs after reset");

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][7:6], VEC[k][5:4]);
            check($sformatf("vec%0d R2-R10 run", k), run_o, VEC[k][3:2], "run_o");
            check($sformatf("vec%0d R3/R4/R7/R9 standby", k), standby_o, VEC[k][1:0], "standby_o");
            check("R11", run_o & standby_o, 2'b00, "run and standby overlap");
        end

        // R8 start and stop pulses
        step(2'b00, 2'b01);
        check("R8", start_o, 2'b01, "start pulse first cycle");
        step(2'b00, 2'b01);
        check("R8", start_o, 2'b00, "start pulse ends");
        step(2'b00, 2'b00);
        check("R8", stop_o, 2'b01, "stop pulse first cycle");
        step(2'b00, 2'b00);
        check("R8", stop_o, 2'b00, "stop pulse ends");

        // R4/R8 paired start pulses on same edge
        step(2'b11, 2'b01);
        step(2'b11, 2'b11);
        check("R4", start_o, 2'b11, "joint start pulses");
        step(2'b11, 2'b00);
        check("R8", stop_o, 2'b11, "joint stop pulses");

        // R1 reset while running
        step(2'b00, 2'b11);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", run_o, 2'b00, "run cleared by reset");
        check("R1", stop_o, 2'b00, "no stop pulse in reset");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule